// File: doc/BRIEF.md
# History-indexed indirect target predictor

This block predicts the destination of indirect jumps and calls. It keeps two direct-mapped target tables. The first is indexed and tagged by the branch address alone. The second is indexed and tagged by a mix of the branch address and a global branch-outcome history. A fetch-side lookup presents an address. One cycle later the block answers with a valid flag, a predicted target, a flag saying which table supplied it, and the history value the lookup used. The front end keeps that history value with the branch and hands it back when the branch resolves.

A branch first lives only in the address table, where its entry carries a bit marking it as indirect. When the address table gives a wrong target for such a branch, the branch gets an entry in the history table for the history that led to it. Branches with a single stable target therefore never use history entries. Branches whose target depends on data fill as many history entries as their behaviour needs. The history entry is chosen only when the address table hits on an entry marked indirect. Otherwise the address table's target is the answer.

The resolution port also carries branch outcomes for non-indirect branches. Every resolution shifts its taken bit into the global history. Taken direct branches may fill the address table with the indirect bit clear. Decisions are made by a named resolution action (IDLE, ADDR_NEW, ADDR_KIND, ADDR_DIRECT, HIST_NEW, HIST_FIX) and a named prediction source (NONE, ADDR, HIST).

Top module: `indir_tgt_pred`

## Requirements
- R1: While reset is held and right after it, pr_vld and pr_from_hist are 0, ghist is 0 and both tables are empty, so a first lookup misses.
- R2: A lookup presented with lk_vld in one cycle is answered on the outputs after the next clock edge. pr_vld is 1 exactly when lk_vld was 1 and the address table entry at index lk_pc[7:2] is valid with tag equal to lk_pc[31:8].
- R3: An indirect resolution (rs_vld=1, rs_ind=1) that misses the address table writes the address entry with tag rs_pc[31:8], target rs_tgt and the indirect bit set. It writes nothing into the history table.
- R4: An indirect resolution with rs_miss=1 that hits an address entry marked indirect writes the history entry at index rs_pc[7:2] ^ rs_hist[5:0] ^ rs_hist[11:6], with tag rs_pc[15:8] ^ rs_hist[7:0] and target rs_tgt. The address entry is left unchanged.
- R5: pr_from_hist is 1 and pr_tgt is the history entry's target exactly when the address table hits on an entry marked indirect and the history table hits under the current ghist (same index and tag formulas as R4). Otherwise pr_tgt is the address entry's target.
- R6: A history table hit with an address entry whose indirect bit is clear gives the address target with pr_from_hist=0.
- R7: A mispredicted indirect resolution whose history entry hits overwrites that entry's target with rs_tgt.
- R8: An indirect resolution with rs_miss=0 that hits an address entry marked indirect changes neither table.
- R9: Every resolution shifts rs_taken into bit 0 of the 12-bit ghist, with older bits moving up. With no resolution, ghist holds. pr_hist reports the ghist value the answered lookup used.
- R10: A non-indirect taken resolution that misses the address table, or has rs_miss=1, writes the address entry with the indirect bit clear. A non-indirect not-taken resolution writes nothing.
- R11: An indirect resolution that hits an address entry with the indirect bit clear rewrites it with the indirect bit set and target rs_tgt, and writes no history entry.
- R12: A lookup in the same cycle as a resolution write sees the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vld | input | 1 | Lookup request |
| lk_pc | input | 32 | Address of the branch being looked up |
| rs_vld | input | 1 | Resolution valid |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_hist | input | 12 | History value recorded at this branch's prediction |
| rs_tgt | input | 32 | Actual target of the resolved branch |
| rs_taken | input | 1 | Resolved direction, shifted into the history |
| rs_ind | input | 1 | Resolved branch is indirect |
| rs_miss | input | 1 | Predicted target was wrong |
| pr_vld | output | 1 | Prediction valid |
| pr_tgt | output | 32 | Predicted target |
| pr_from_hist | output | 1 | Prediction came from the history table |
| pr_hist | output | 12 | History used by the answered lookup |
| ghist | output | 12 | Current global history |

## Verification
Some properties are checked by assertions on every cycle. These are: the shift and hold of the history, the absence of a prediction after an idle lookup cycle, and that a history-sourced answer always comes with a valid address hit. They also cover the write actions: never two tables at once, history writes only behind an indirect address hit, and silence on correct indirect and not-taken direct resolutions. The bench scenarios show what only stored state reveals. These are promotion into the history table and selection of its target, overwrite of a history entry, an aliasing history entry that must not be used for a direct branch, reclassification of a direct entry, and read-before-write when lookup and update share a cycle. A behavioural model compares every output on every clock.

// File: rtl/indir_tgt_pkg.sv
package indir_tgt_pkg;

    // Action chosen for one resolution
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_ADDR_NEW,
        ACT_ADDR_KIND,
        ACT_ADDR_DIRECT,
        ACT_HIST_NEW,
        ACT_HIST_FIX
    } itp_act_e;

    // Source of one prediction
    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_ADDR,
        SRC_HIST
    } itp_src_e;

endpackage

// File: rtl/itp_tbl.sv
module itp_tbl #(
    parameter int IW = 6,
    parameter int TW = 24,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra_idx,
    input  logic [TW-1:0] ra_tag,
    output logic          ra_hit,
    output logic [DW-1:0] ra_dat,
    input  logic [IW-1:0] rb_idx,
    input  logic [TW-1:0] rb_tag,
    output logic          rb_hit,
    output logic [DW-1:0] rb_dat,
    input  logic          we,
    input  logic [IW-1:0] w_idx,
    input  logic [TW-1:0] w_tag,
    input  logic [DW-1:0] w_dat
);
    localparam int ENT = 1 << IW;

    logic [ENT-1:0] vld_q;
    logic [TW-1:0]  tag_q [ENT];
    logic [DW-1:0]  dat_q [ENT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (we) begin
            vld_q[w_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[w_idx] <= w_tag;
            dat_q[w_idx] <= w_dat;
        end
    end

    assign ra_hit = vld_q[ra_idx] && (tag_q[ra_idx] == ra_tag);
    assign ra_dat = dat_q[ra_idx];
    assign rb_hit = vld_q[rb_idx] && (tag_q[rb_idx] == rb_tag);
    assign rb_dat = dat_q[rb_idx];

    // A written slot is valid afterwards (R3)
    assert_write_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> vld_q[$past(w_idx)]);

endmodule

// File: rtl/itp_upd.sv
module itp_upd
    import indir_tgt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rs_vld,
    input  logic rs_ind,
    input  logic rs_taken,
    input  logic rs_miss,
    input  logic a_hit,
    input  logic a_ind,
    input  logic h_hit,
    output logic a_we,
    output logic a_kind,
    output logic h_we
);
    itp_act_e act;

    always_comb begin
        act = ACT_IDLE;
        if (rs_vld) begin
            if (rs_ind) begin
                if (!a_hit) begin
                    act = ACT_ADDR_NEW;
                end else if (!a_ind) begin
                    act = ACT_ADDR_KIND;
                end else if (rs_miss) begin
                    act = h_hit ? ACT_HIST_FIX : ACT_HIST_NEW;
                end
            end else if (rs_taken && (!a_hit || rs_miss)) begin
                act = ACT_ADDR_DIRECT;
            end
        end
    end

    always_comb begin
        a_we   = 1'b0;
        a_kind = 1'b0;
        h_we   = 1'b0;
        unique case (act)
            ACT_IDLE: ;
            ACT_ADDR_NEW, ACT_ADDR_KIND: begin
                a_we   = 1'b1;
                a_kind = 1'b1;
            end
            ACT_ADDR_DIRECT: a_we = 1'b1;
            ACT_HIST_NEW, ACT_HIST_FIX: h_we = 1'b1;
            default: ;
        endcase
    end

    assert_one_table_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_we && h_we));
    assert_hist_behind_ind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        h_we |-> (a_hit && a_ind));
    assert_quiet_correct_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_vld && rs_ind && !rs_miss && a_hit && a_ind) |-> !(a_we || h_we));
    assert_quiet_not_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_vld && !rs_ind && !rs_taken) |-> !(a_we || h_we));

endmodule

// File: rtl/indir_tgt_pred.sv
module indir_tgt_pred
    import indir_tgt_pkg::*;
#(
    parameter int AW  = 32,
    parameter int HW  = 12,
    parameter int IW  = 6,
    parameter int PTW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_vld,
    input  logic [AW-1:0] lk_pc,
    input  logic          rs_vld,
    input  logic [AW-1:0] rs_pc,
    input  logic [HW-1:0] rs_hist,
    input  logic [AW-1:0] rs_tgt,
    input  logic          rs_taken,
    input  logic          rs_ind,
    input  logic          rs_miss,
    output logic          pr_vld,
    output logic [AW-1:0] pr_tgt,
    output logic          pr_from_hist,
    output logic [HW-1:0] pr_hist,
    output logic [HW-1:0] ghist
);
    localparam int ATW = AW - IW - 2;
    localparam int ADW = AW + 1;

    function automatic logic [IW-1:0] fold_h(input logic [HW-1:0] h);
        logic [IW-1:0] r;
        r = '0;
        for (int i = 0; i < HW; i++) begin
            r[i % IW] = r[i % IW] ^ h[i];
        end
        return r;
    endfunction

    logic [HW-1:0] ghist_q;

    // index and tag for both ports
    logic [IW-1:0]  lk_aidx, rs_aidx, lk_hidx, rs_hidx;
    logic [ATW-1:0] lk_atag, rs_atag;
    logic [PTW-1:0] lk_htag, rs_htag;

    assign lk_aidx = lk_pc[IW+1:2];
    assign rs_aidx = rs_pc[IW+1:2];
    assign lk_atag = lk_pc[AW-1:IW+2];
    assign rs_atag = rs_pc[AW-1:IW+2];
    assign lk_hidx = lk_pc[IW+1:2] ^ fold_h(ghist_q);
    assign rs_hidx = rs_pc[IW+1:2] ^ fold_h(rs_hist);
    assign lk_htag = lk_pc[IW+2 +: PTW] ^ ghist_q[PTW-1:0];
    assign rs_htag = rs_pc[IW+2 +: PTW] ^ rs_hist[PTW-1:0];

    logic           a_lk_hit, a_rs_hit, h_lk_hit, h_rs_hit;
    logic [ADW-1:0] a_lk_dat, a_rs_dat;
    logic [AW-1:0]  h_lk_dat, h_rs_dat;
    logic           a_we, a_kind, h_we;

    itp_tbl #(.IW(IW), .TW(ATW), .DW(ADW)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (lk_aidx),
        .ra_tag (lk_atag),
        .ra_hit (a_lk_hit),
        .ra_dat (a_lk_dat),
        .rb_idx (rs_aidx),
        .rb_tag (rs_atag),
        .rb_hit (a_rs_hit),
        .rb_dat (a_rs_dat),
        .we     (a_we),
        .w_idx  (rs_aidx),
        .w_tag  (rs_atag),
        .w_dat  ({a_kind, rs_tgt})
    );

    itp_tbl #(.IW(IW), .TW(PTW), .DW(AW)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (lk_hidx),
        .ra_tag (lk_htag),
        .ra_hit (h_lk_hit),
        .ra_dat (h_lk_dat),
        .rb_idx (rs_hidx),
        .rb_tag (rs_htag),
        .rb_hit (h_rs_hit),
        .rb_dat (h_rs_dat),
        .we     (h_we),
        .w_idx  (rs_hidx),
        .w_tag  (rs_htag),
        .w_dat  (rs_tgt)
    );

    itp_upd u_upd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rs_vld   (rs_vld),
        .rs_ind   (rs_ind),
        .rs_taken (rs_taken),
        .rs_miss  (rs_miss),
        .a_hit    (a_rs_hit),
        .a_ind    (a_rs_dat[AW]),
        .h_hit    (h_rs_hit),
        .a_we     (a_we),
        .a_kind   (a_kind),
        .h_we     (h_we)
    );

    logic unused_bits;
    assign unused_bits = ^{a_rs_dat[AW-1:0], h_rs_dat, lk_pc[1:0], rs_pc[1:0]};

    // history register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ghist_q <= '0;
        end else if (rs_vld) begin
            ghist_q <= {ghist_q[HW-2:0], rs_taken};
        end
    end

    // prediction source
    itp_src_e src;

    always_comb begin
        src = SRC_NONE;
        if (lk_vld && a_lk_hit) begin
            src = (a_lk_dat[AW] && h_lk_hit) ? SRC_HIST : SRC_ADDR;
        end
    end

    logic          pr_vld_q, pr_fh_q;
    logic [AW-1:0] pr_tgt_q;
    logic [HW-1:0] pr_hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_vld_q  <= 1'b0;
            pr_fh_q   <= 1'b0;
            pr_tgt_q  <= '0;
            pr_hist_q <= '0;
        end else begin
            pr_hist_q <= ghist_q;
            unique case (src)
                SRC_ADDR: begin
                    pr_vld_q <= 1'b1;
                    pr_fh_q  <= 1'b0;
                    pr_tgt_q <= a_lk_dat[AW-1:0];
                end
                SRC_HIST: begin
                    pr_vld_q <= 1'b1;
                    pr_fh_q  <= 1'b1;
                    pr_tgt_q <= h_lk_dat;
                end
                default: begin
                    pr_vld_q <= 1'b0;
                    pr_fh_q  <= 1'b0;
                    pr_tgt_q <= '0;
                end
            endcase
        end
    end

    assign pr_vld       = pr_vld_q;
    assign pr_from_hist = pr_fh_q;
    assign pr_tgt       = pr_tgt_q;
    assign pr_hist      = pr_hist_q;
    assign ghist        = ghist_q;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!pr_vld && !pr_from_hist && ghist == '0));
    assert_idle_no_pred_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_vld |=> !pr_vld);
    assert_hist_needs_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pr_from_hist |-> pr_vld);
    assert_hist_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rs_vld |=> ghist == {$past(ghist[HW-2:0]), $past(rs_taken)});
    assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_vld |=> $stable(ghist));

endmodule

// File: tb/sim_indir_tgt_pred.sv
`timescale 1ns/1ps
module sim_indir_tgt_pred;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_vld;
    logic [31:0] lk_pc;
    logic        rs_vld;
    logic [31:0] rs_pc;
    logic [11:0] rs_hist;
    logic [31:0] rs_tgt;
    logic        rs_taken, rs_ind, rs_miss;
    logic        pr_vld, pr_from_hist;
    logic [31:0] pr_tgt;
    logic [11:0] pr_hist, ghist;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    indir_tgt_pred u0 (
        .clk(clk), .rst_n(rst_n), .lk_vld(lk_vld), .lk_pc(lk_pc),
        .rs_vld(rs_vld), .rs_pc(rs_pc), .rs_hist(rs_hist), .rs_tgt(rs_tgt),
        .rs_taken(rs_taken), .rs_ind(rs_ind), .rs_miss(rs_miss),
        .pr_vld(pr_vld), .pr_tgt(pr_tgt), .pr_from_hist(pr_from_hist),
        .pr_hist(pr_hist), .ghist(ghist)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [23:0] ma_tag [int];
    logic [31:0] ma_tgt [int];
    bit          ma_ind [int];
    logic [7:0]  mh_tag [int];
    logic [31:0] mh_tgt [int];
    logic [11:0] m_gh;
    logic        e_vld, e_fh;
    logic [31:0] e_tgt;
    logic [11:0] e_ph;

    function automatic int hix(logic [31:0] pc, logic [11:0] h);
        return int'(pc[7:2] ^ h[5:0] ^ h[11:6]);
    endfunction
    function automatic logic [7:0] htg(logic [31:0] pc, logic [11:0] h);
        return pc[15:8] ^ h[7:0];
    endfunction
    function automatic bit ahit(logic [31:0] pc);
        return ma_tag.exists(int'(pc[7:2])) && ma_tag[int'(pc[7:2])] == pc[31:8];
    endfunction
    function automatic bit hhit(logic [31:0] pc, logic [11:0] h);
        return mh_tag.exists(hix(pc, h)) && mh_tag[hix(pc, h)] == htg(pc, h);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ma_tag.delete(); ma_tgt.delete(); ma_ind.delete();
            mh_tag.delete(); mh_tgt.delete();
            m_gh = '0; e_vld = 0; e_fh = 0; e_tgt = '0; e_ph = '0;
        end else begin
            e_ph = m_gh; e_vld = 0; e_fh = 0; e_tgt = '0;
            if (lk_vld && ahit(lk_pc)) begin
                e_vld = 1;
                if (ma_ind[int'(lk_pc[7:2])] && hhit(lk_pc, m_gh)) begin
                    e_fh = 1; e_tgt = mh_tgt[hix(lk_pc, m_gh)];
                end else begin
                    e_tgt = ma_tgt[int'(lk_pc[7:2])];
                end
            end
            if (rs_vld) begin
                if (rs_ind) begin
                    if (!ahit(rs_pc) || !ma_ind[int'(rs_pc[7:2])]) begin
                        ma_tag[int'(rs_pc[7:2])] = rs_pc[31:8];
                        ma_tgt[int'(rs_pc[7:2])] = rs_tgt;
                        ma_ind[int'(rs_pc[7:2])] = 1;
                    end else if (rs_miss) begin
                        mh_tag[hix(rs_pc, rs_hist)] = htg(rs_pc, rs_hist);
                        mh_tgt[hix(rs_pc, rs_hist)] = rs_tgt;
                    end
                end else if (rs_taken && (!ahit(rs_pc) || rs_miss)) begin
                    ma_tag[int'(rs_pc[7:2])] = rs_pc[31:8];
                    ma_tgt[int'(rs_pc[7:2])] = rs_tgt;
                    ma_ind[int'(rs_pc[7:2])] = 0;
                end
                m_gh = {m_gh[10:0], rs_taken};
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk("R2", "model pr_vld", 32'(pr_vld), 32'(e_vld));
            if (e_vld) chk("R5", "model pr_tgt", pr_tgt, e_tgt);
            chk("R5", "model pr_from_hist", 32'(pr_from_hist), 32'(e_fh));
            chk("R9", "model pr_hist", 32'(pr_hist), 32'(e_ph));
            chk("R9", "model ghist", 32'(ghist), 32'(m_gh));
        end
    end

    // ---------------- stimulus ----------------
    task automatic resolve(input logic [31:0] pc, input logic [11:0] h,
                           input logic [31:0] t, input logic tk,
                           input logic ind, input logic ms);
        rs_vld = 1; rs_pc = pc; rs_hist = h; rs_tgt = t;
        rs_taken = tk; rs_ind = ind; rs_miss = ms;
        @(negedge clk);
        rs_vld = 0;
    endtask

    task automatic lookup(input logic [31:0] pc, input logic ev,
                          input logic [31:0] et, input logic efh,
                          input string req);
        lk_vld = 1; lk_pc = pc;
        @(negedge clk);
        lk_vld = 0;
        chk(req, "pr_vld", 32'(pr_vld), 32'(ev));
        if (ev) chk(req, "pr_tgt", pr_tgt, et);
        chk(req, "pr_from_hist", 32'(pr_from_hist), 32'(efh));
    endtask

    localparam logic [31:0] PC_A = 32'h0000_1040;
    localparam logic [31:0] PC_D = 32'h0000_2080;
    localparam logic [31:0] PC_E = 32'h0000_2090;
    localparam logic [31:0] PC_N = 32'h0000_3004;
    localparam logic [31:0] PC_F = 32'h0000_4100;

    initial begin
        rst_n = 0; lk_vld = 0; lk_pc = '0; rs_vld = 0; rs_pc = '0;
        rs_hist = '0; rs_tgt = '0; rs_taken = 0; rs_ind = 0; rs_miss = 0;
        repeat (3) @(negedge clk);
        chk("R1", "pr_vld in reset", 32'(pr_vld), 32'd0);
        chk("R1", "ghist in reset", 32'(ghist), 32'd0);
        rst_n = 1;
        @(negedge clk);
        lookup(PC_A, 0, 32'h0, 0, "R1");
        // first sighting goes to the address table only
        resolve(PC_A, 12'h000, 32'h0000_2000, 1, 1, 1);
        chk("R9", "ghist after one taken", 32'(ghist), 32'h001);
        lookup(PC_A, 1, 32'h0000_2000, 0, "R3");
        chk("R9", "pr_hist", 32'(pr_hist), 32'h001);
        // address table wrong: promote into the history table
        resolve(PC_A, 12'h003, 32'h0000_3000, 1, 1, 1);
        lookup(PC_A, 1, 32'h0000_3000, 1, "R4");
        // correct prediction writes nothing
        resolve(PC_A, 12'h007, 32'h0000_3333, 1, 1, 0);
        lookup(PC_A, 1, 32'h0000_2000, 0, "R8");
        // allocate then overwrite the same history entry
        resolve(PC_A, 12'h01F, 32'h0000_4000, 1, 1, 1);
        resolve(PC_A, 12'h01F, 32'h0000_4400, 1, 1, 1);
        lookup(PC_A, 1, 32'h0000_4400, 1, "R7");
        // direct branch whose history slot aliases another branch's entry
        resolve(PC_D, 12'h000, 32'h0000_5000, 1, 0, 1);
        resolve(PC_E, 12'h000, 32'h0000_6000, 1, 1, 1);
        resolve(PC_E, 12'h1FF, 32'h0000_6600, 1, 1, 1);
        chk("R9", "ghist before alias lookup", 32'(ghist), 32'h0FF);
        lookup(PC_D, 1, 32'h0000_5000, 0, "R6");
        chk("R10", "direct taken allocated", 32'(pr_vld), 32'd1);
        // not-taken direct leaves no entry
        resolve(PC_N, 12'h000, 32'h0000_9999, 0, 0, 0);
        lookup(PC_N, 0, 32'h0, 0, "R10");
        // indirect resolution reclassifies a direct entry
        resolve(PC_D, 12'h3FD, 32'h0000_7000, 1, 1, 1);
        lookup(PC_D, 1, 32'h0000_7000, 0, "R11");
        // lookup and write in the same cycle
        rs_vld = 1; rs_pc = PC_F; rs_hist = 12'h000; rs_tgt = 32'h0000_8000;
        rs_taken = 1; rs_ind = 1; rs_miss = 1;
        lk_vld = 1; lk_pc = PC_F;
        @(negedge clk);
        rs_vld = 0; lk_vld = 0;
        chk("R12", "same-cycle lookup", 32'(pr_vld), 32'd0);
        lookup(PC_F, 1, 32'h0000_8000, 0, "R12");
        repeat (2) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule